// File: doc/BRIEF.md
# System Management Interrupt Controller

This block collects power-management events from a set of interrupt lines, an external request pin, a software trigger strobe and an inactivity timer. It records each enabled event in a sticky status bit, and it merges the pending enabled events into one registered, active-low interrupt output. A gate bit in the control register decides whether that output may assert. Recording is independent of the gate, so an event taken while the output is masked stays pending. The output then asserts as soon as software opens the gate.

An inactivity countdown timer starts from a software-writable reload value. Per-source activity strobes can be enabled as system events, which reload the timer, or as break events, which wake the system by releasing the active-low stop-clock output. Software sets a sleep bit to drive that output low. When the timer reaches zero it raises its own interrupt source once and then holds at zero until it is loaded again. A plain synchronous register bus gives access to all registers. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `smi_ctrl`

## Requirements
- R1: While reset is held, the registers read as follows: control, enable, event-enable and status read 0, and the count register reads the reload reset value. `smi_n_o` and `stpclk_n_o` are both 1.
- R2: While the gate (control address 0, bit 0) is 0, `smi_n_o` stays 1. Enabled events are still recorded in the status register (address 3) during that time.
- R3: If an enabled status bit is already set when software writes gate=1, `smi_n_o` goes low at the clock edge after the edge that captures the write.
- R4: Status bit k is set only when enable bit k (address 1) is 1. The source mapping is:
  - bits 0 to 4 are set on a rising edge of `irq_i[0]` to `irq_i[4]` (keyboard, serial A, serial B, RTC alarm, mouse); a line held high records once;
  - bit 5 is set by timer expiry;
  - bit 6 is set on a falling edge of `ext_smi_n_i`;
  - bit 7 is set by a one-cycle `sw_trig_i` strobe.
- R5: Status bits are sticky. Writing 1 to a bit at address 3 clears it, and writing 0 has no effect. An event that arrives in the same cycle as its clear leaves the bit set.
- R6: Address 1 keeps bits 7:0. Bits 31:8 of address 1 read 0. Address 2 keeps bits ACT_W-1:0 (system-event enables) and bits 16+ACT_W-1:16 (break-event enables), and all other bits read 0.
- R7: A write that sets the gate and an event arriving in the same cycle both take effect: the status bit is recorded and the gate reads 1. `smi_n_o` falls one edge later.
- R8: A write to the reload register (address 4) also loads the counter (address 5). The counter then decrements once per clock. On the edge where it reaches 0 it sets status bit 5 (if enabled) once. It stays at 0 until it is loaded again.
- R9: A pulse on `act_i[j]` with event-enable bit j set reloads the counter from the reload register on that edge. Activity on a source without that enable leaves the countdown running.
- R10: Control bit 1 set to 1 drives `stpclk_n_o` low. A pulse on `act_i[j]` with event-enable bit 16+j set drives it high and clears control bit 1, and this wins over a simultaneous write of 1 to that bit.
- R11: `smi_n_o` asserts in the same way whether `stpclk_n_o` is low or high.
- R12: `smi_n_o` is the registered inverse of gate AND (any status bit that is set and enabled). It returns to 1 one edge after the last such bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 5 | Interrupt lines: keyboard, serial A, serial B, RTC alarm, mouse |
| ext_smi_n_i | input | 1 | External interrupt request, active low |
| sw_trig_i | input | 1 | Software trigger strobe, one cycle |
| act_i | input | ACT_W | Per-source activity strobes |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| smi_n_o | output | 1 | System management interrupt, active low |
| stpclk_n_o | output | 1 | Stop-clock request, active low |

## Verification
The bench builds the block with ACT_W=4, TMR_W=8 and a reload reset value of 60. With these values the full expiry sequence can be stepped through cycle by cycle in a few dozen cycles: load, countdown, single status pulse and hold at zero. The four-bit activity width leaves unused bits on both halves of the event-enable register, which exposes the reserved-bit masking. The defaults (16-bit counter, 65535 reload) behave identically apart from the time taken to expire.

// File: rtl/smi_pkg.sv
// Shared constants for the system management interrupt controller:
// register addresses and status source positions.
package smi_pkg;
    localparam int          REG_AW      = 3;
    localparam int          NSRC        = 8;
    localparam int          NIRQ        = 5;
    localparam int          SRC_TMR     = 5;
    localparam int          SRC_EXT     = 6;
    localparam int          SRC_SW      = 7;
    localparam int          BRK_LSB     = 16;
    localparam logic [2:0]  ADDR_CTRL   = 3'd0;
    localparam logic [2:0]  ADDR_SMIEN  = 3'd1;
    localparam logic [2:0]  ADDR_EVEN   = 3'd2;
    localparam logic [2:0]  ADDR_STAT   = 3'd3;
    localparam logic [2:0]  ADDR_RELOAD = 3'd4;
    localparam logic [2:0]  ADDR_COUNT  = 3'd5;
endpackage

// File: rtl/smi_regs.sv
// Register file: control (gate, sleep), source enables, event enables,
// timer reload, plus the combinational read mux.
// Assumes ACT_W <= 16 and TMR_W <= 32; reads have no side effects.
module smi_regs
    import smi_pkg::*;
#(
    parameter int ACT_W      = 8,
    parameter int TMR_W      = 16,
    parameter int RELOAD_RST = 65535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    input  logic [NSRC-1:0]   status_i,
    input  logic [TMR_W-1:0]  count_i,
    input  logic              brk_hit_i,
    output logic              gate_o,
    output logic              sleep_o,
    output logic [NSRC-1:0]   smi_en_o,
    output logic [ACT_W-1:0]  sys_en_o,
    output logic [ACT_W-1:0]  brk_en_o,
    output logic [TMR_W-1:0]  reload_o,
    output logic              reload_wr_o,
    output logic [NSRC-1:0]   stat_clr_o
);
    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    // Write-strobe decode for the timer load and status clear.
    assign reload_wr_o = wr_i && (addr_i == ADDR_RELOAD);
    assign stat_clr_o  = (wr_i && (addr_i == ADDR_STAT)) ? wdata_i[NSRC-1:0] : '0;

    // Gate bit and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_o   <= 1'b0;
            smi_en_o <= '0;
            sys_en_o <= '0;
            brk_en_o <= '0;
            reload_o <= TMR_W'(RELOAD_RST);
        end else if (wr_i) begin
            case (addr_i)
                ADDR_CTRL:   gate_o   <= wdata_i[0];
                ADDR_SMIEN:  smi_en_o <= wdata_i[NSRC-1:0];
                ADDR_EVEN: begin
                    sys_en_o <= wdata_i[ACT_W-1:0];
                    brk_en_o <= wdata_i[BRK_LSB +: ACT_W];
                end
                ADDR_RELOAD: reload_o <= wdata_i[TMR_W-1:0];
                default: ;
            endcase
        end
    end

    // Sleep bit: a break event wakes, and wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sleep_o <= 1'b0;
        else if (brk_hit_i)
            sleep_o <= 1'b0;
        else if (wr_i && (addr_i == ADDR_CTRL))
            sleep_o <= wdata_i[1];
    end

    // Read mux; unused and reserved bits return zero.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTRL:   rdata_o[1:0] = {sleep_o, gate_o};
            ADDR_SMIEN:  rdata_o[NSRC-1:0] = smi_en_o;
            ADDR_EVEN: begin
                rdata_o[ACT_W-1:0]         = sys_en_o;
                rdata_o[BRK_LSB +: ACT_W]  = brk_en_o;
            end
            ADDR_STAT:   rdata_o[NSRC-1:0] = status_i;
            ADDR_RELOAD: rdata_o[TMR_W-1:0] = reload_o;
            ADDR_COUNT:  rdata_o[TMR_W-1:0] = count_i;
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/smi_status.sv
// Event detection and sticky status. Interrupt lines record on a rising
// edge, the external pin on a falling edge, the software and timer sources
// on a one-cycle pulse. Inputs are assumed synchronous to clk.
module smi_status
    import smi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_i,
    input  logic            ext_smi_n_i,
    input  logic            sw_trig_i,
    input  logic            tmr_exp_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] status_o
);
    logic [NIRQ-1:0] irq_q;
    logic            ext_q;
    logic [NSRC-1:0] ev;

    // Previous-cycle samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            ext_q <= 1'b1;
        end else begin
            irq_q <= irq_i;
            ext_q <= ext_smi_n_i;
        end
    end

    // Raw event vector in status bit order.
    always_comb begin
        ev[NIRQ-1:0] = irq_i & ~irq_q;
        ev[SRC_TMR]  = tmr_exp_i;
        ev[SRC_EXT]  = ext_q & ~ext_smi_n_i;
        ev[SRC_SW]   = sw_trig_i;
    end

    // One sticky bit per source; a new event beats a same-cycle clear.
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                status_o[i] <= 1'b0;
            else
                status_o[i] <= (status_o[i] & ~clr_i[i]) | (ev[i] & en_i[i]);
        end
    end
endmodule

// File: rtl/smi_idle_timer.sv
// Inactivity down-counter. A load takes priority over counting; expiry
// pulses on the cycle the counter steps from 1 to 0, then it holds at 0.
module smi_idle_timer #(
    parameter int TMR_W      = 16,
    parameter int RELOAD_RST = 65535
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_load_i,
    input  logic [TMR_W-1:0] sw_val_i,
    input  logic             act_load_i,
    input  logic [TMR_W-1:0] reload_i,
    output logic [TMR_W-1:0] count_o,
    output logic             expire_o
);
    logic load;
    assign load     = sw_load_i | act_load_i;
    assign expire_o = !load && (count_o == TMR_W'(1));

    // Count down, reload on request, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_o <= TMR_W'(RELOAD_RST);
        else if (sw_load_i)
            count_o <= sw_val_i;
        else if (act_load_i)
            count_o <= reload_i;
        else if (count_o != '0)
            count_o <= count_o - 1'b1;
    end
endmodule

// File: rtl/smi_ctrl.sv
// Top level: ties register file, status logic and idle timer together,
// and registers the active-low interrupt output.
module smi_ctrl
    import smi_pkg::*;
#(
    parameter int ACT_W      = 8,
    parameter int TMR_W      = 16,
    parameter int RELOAD_RST = 65535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIRQ-1:0]   irq_i,
    input  logic              ext_smi_n_i,
    input  logic              sw_trig_i,
    input  logic [ACT_W-1:0]  act_i,
    input  logic              bus_wr_i,
    input  logic [REG_AW-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              smi_n_o,
    output logic              stpclk_n_o
);
    logic             gate, sleep, reload_wr, tmr_exp, brk_hit, sys_hit;
    logic [NSRC-1:0]  smi_en, stat_clr, status;
    logic [ACT_W-1:0] sys_en, brk_en;
    logic [TMR_W-1:0] reload, count;

    assign brk_hit    = |(act_i & brk_en);
    assign sys_hit    = |(act_i & sys_en);
    assign stpclk_n_o = ~sleep;

    smi_regs #(.ACT_W(ACT_W), .TMR_W(TMR_W), .RELOAD_RST(RELOAD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .status_i(status),
        .count_i(count), .brk_hit_i(brk_hit), .gate_o(gate), .sleep_o(sleep),
        .smi_en_o(smi_en), .sys_en_o(sys_en), .brk_en_o(brk_en),
        .reload_o(reload), .reload_wr_o(reload_wr), .stat_clr_o(stat_clr)
    );

    smi_status u_status (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ext_smi_n_i(ext_smi_n_i),
        .sw_trig_i(sw_trig_i), .tmr_exp_i(tmr_exp), .en_i(smi_en),
        .clr_i(stat_clr), .status_o(status)
    );

    smi_idle_timer #(.TMR_W(TMR_W), .RELOAD_RST(RELOAD_RST)) u_timer (
        .clk(clk), .rst_n(rst_n), .sw_load_i(reload_wr),
        .sw_val_i(bus_wdata_i[TMR_W-1:0]), .act_load_i(sys_hit),
        .reload_i(reload), .count_o(count), .expire_o(tmr_exp)
    );

    // Glitch-free output: gate AND any enabled pending source, registered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            smi_n_o <= 1'b1;
        else
            smi_n_o <= ~(gate & |(status & smi_en));
    end
endmodule

// File: rtl/smi_ctrl_chk.sv
// Temporal checks on smi_ctrl, attached by bind. Observes only.
module smi_ctrl_chk
    import smi_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate,
    input logic              smi_n,
    input logic              stpclk_n,
    input logic [NSRC-1:0]   status,
    input logic [NSRC-1:0]   smi_en,
    input logic              sw_trig,
    input logic              brk_hit,
    input logic              tmr_load,
    input logic [TMR_W-1:0]  count,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [31:0]       bus_rdata
);
    // R2
    gate_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |=> smi_n);
    // R6
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_SMIEN) |-> (bus_rdata[31:8] == '0));
    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_STAT) |=> ((status & $past(status)) == $past(status)));
    // R8
    tmr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !tmr_load) |=> (count == '0));
    // R10
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_hit |=> stpclk_n);
    // R4
    sw_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig && smi_en[SRC_SW]) |=> status[SRC_SW]);
    // R12
    smi_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && |(status & smi_en)) |=> !smi_n);
endmodule

bind smi_ctrl smi_ctrl_chk #(.TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gate(gate), .smi_n(smi_n_o),
    .stpclk_n(stpclk_n_o), .status(status), .smi_en(smi_en),
    .sw_trig(sw_trig_i), .brk_hit(brk_hit), .tmr_load(reload_wr | sys_hit),
    .count(count), .bus_wr(bus_wr_i), .bus_addr(bus_addr_i),
    .bus_rdata(bus_rdata_o)
);

// File: tb/smi_ctrl_bench.sv
// Directed bench for smi_ctrl: one task per scenario, each self-checking.
module smi_ctrl_bench;
    localparam int ACT_W = 4;
    localparam int TMR_W = 8;
    localparam int RLD   = 60;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [4:0]       irq_i = '0;
    logic             ext_smi_n_i = 1'b1;
    logic             sw_trig_i = 1'b0;
    logic [ACT_W-1:0] act_i = '0;
    logic             bus_wr_i = 1'b0;
    logic [2:0]       bus_addr_i = '0;
    logic [31:0]      bus_wdata_i = '0;
    logic [31:0]      bus_rdata_o;
    logic             smi_n_o, stpclk_n_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    smi_ctrl #(.ACT_W(ACT_W), .TMR_W(TMR_W), .RELOAD_RST(RLD)) u_smi_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .ext_smi_n_i(ext_smi_n_i),
        .sw_trig_i(sw_trig_i), .act_i(act_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .smi_n_o(smi_n_o), .stpclk_n_o(stpclk_n_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic pulse_irq(input int i);
        irq_i[i] = 1'b1;
        @(negedge clk);
        irq_i[i] = 1'b0;
    endtask

    task automatic pulse_act(input int j);
        act_i[j] = 1'b1;
        @(negedge clk);
        act_i[j] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk(v, 0, "R1 ctrl");
        rd(3'd1, v); chk(v, 0, "R1 enable");
        rd(3'd2, v); chk(v, 0, "R1 event enable");
        rd(3'd3, v); chk(v, 0, "R1 status");
        rd(3'd5, v); chk(v, RLD, "R1 count");
        chk({31'd0, smi_n_o}, 1, "R1 smi_n");
        chk({31'd0, stpclk_n_o}, 1, "R1 stpclk_n");
    endtask

    task automatic t_masked();
        logic [31:0] v;
        wr(3'd1, 32'h01);
        pulse_irq(0);
        pulse_irq(1);                   // not enabled: R4
        rd(3'd3, v); chk(v, 32'h01, "R2/R4 recorded while gated");
        step(2);
        chk({31'd0, smi_n_o}, 1, "R2 output masked");
        wr(3'd3, 32'h00);
        rd(3'd3, v); chk(v, 32'h01, "R5 write zero keeps");
    endtask

    task automatic t_open_gate();
        logic [31:0] v;
        wr(3'd0, 32'h1);
        chk({31'd0, smi_n_o}, 1, "R3 not yet");
        step(1);
        chk({31'd0, smi_n_o}, 0, "R3 asserts after gate");
        wr(3'd3, 32'h01);
        rd(3'd3, v); chk(v, 0, "R5 w1c clears");
        step(1);
        chk({31'd0, smi_n_o}, 1, "R12 deasserts after clear");
    endtask

    task automatic t_sources();
        logic [31:0] v;
        wr(3'd1, 32'hDF);
        irq_i[2] = 1'b1; step(3); irq_i[2] = 1'b0;   // held high: one record
        pulse_irq(3);
        pulse_irq(4);
        sw_trig_i = 1'b1; step(1); sw_trig_i = 1'b0;
        ext_smi_n_i = 1'b0; step(1);
        rd(3'd3, v); chk(v, 32'hDC, "R4 all source bits");
        wr(3'd3, 32'h40);
        step(2);
        rd(3'd3, v); chk(v, 32'h9C, "R4 ext level held records once");
        ext_smi_n_i = 1'b1;
        wr(3'd3, 32'hFF);
        step(1);
        // same-cycle event and clear on bit 3
        bus_wr_i = 1'b1; bus_addr_i = 3'd3; bus_wdata_i = 32'h08; irq_i[3] = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0; irq_i[3] = 1'b0;
        rd(3'd3, v); chk(v, 32'h08, "R5 event beats clear");
        wr(3'd3, 32'hFF);
    endtask

    task automatic t_gate_same_cycle();
        logic [31:0] v;
        wr(3'd0, 32'h0);
        step(1);
        bus_wr_i = 1'b1; bus_addr_i = 3'd0; bus_wdata_i = 32'h1; sw_trig_i = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0; sw_trig_i = 1'b0;
        rd(3'd3, v); chk(v, 32'h80, "R7 event recorded");
        rd(3'd0, v); chk(v, 32'h1, "R7 gate set");
        chk({31'd0, smi_n_o}, 1, "R7 not yet");
        step(1);
        chk({31'd0, smi_n_o}, 0, "R7 asserts");
        wr(3'd3, 32'hFF);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, v); chk(v, 32'hFF, "R6 enable reserved");
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk(v, 32'h000F_000F, "R6 event enable reserved");
        wr(3'd2, 32'h0);
        wr(3'd1, 32'hDF);
    endtask

    task automatic t_timer();
        logic [31:0] v;
        wr(3'd4, 32'h0);
        wr(3'd1, 32'hFF);
        wr(3'd4, 32'd5);
        rd(3'd5, v); chk(v, 5, "R8 write loads counter");
        step(4);
        rd(3'd5, v); chk(v, 1, "R8 count 1");
        rd(3'd3, v); chk(v, 0, "R8 not expired yet");
        step(1);
        rd(3'd3, v); chk(v, 32'h20, "R8 expiry sets bit 5");
        step(3);
        rd(3'd5, v); chk(v, 0, "R8 holds at zero");
        wr(3'd3, 32'h20);
        step(5);
        rd(3'd3, v); chk(v, 0, "R8 fires once");
    endtask

    task automatic t_sysevent();
        logic [31:0] v;
        wr(3'd2, 32'h1);
        wr(3'd4, 32'd20);
        step(5);
        rd(3'd5, v); chk(v, 15, "R9 counting");
        pulse_act(0);
        rd(3'd5, v); chk(v, 20, "R9 system event reloads");
        pulse_act(1);
        rd(3'd5, v); chk(v, 19, "R9 non-enabled activity ignored");
    endtask

    task automatic t_break();
        logic [31:0] v;
        wr(3'd1, 32'h01);
        wr(3'd0, 32'h3);
        chk({31'd0, stpclk_n_o}, 0, "R10 sleep drives low");
        pulse_irq(0);
        step(1);
        chk({31'd0, smi_n_o}, 0, "R11 asserts while stopped");
        wr(3'd3, 32'hFF);
        pulse_act(1);
        chk({31'd0, stpclk_n_o}, 0, "R10 no break enable");
        wr(3'd2, 32'h0002_0001);
        pulse_act(1);
        chk({31'd0, stpclk_n_o}, 1, "R10 break wakes");
        rd(3'd0, v); chk(v, 32'h1, "R10 sleep bit cleared");
        bus_wr_i = 1'b1; bus_addr_i = 3'd0; bus_wdata_i = 32'h3; act_i[1] = 1'b1;
        @(negedge clk);
        bus_wr_i = 1'b0; act_i[1] = 1'b0;
        chk({31'd0, stpclk_n_o}, 1, "R10 break beats write");
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_masked();
        t_open_gate();
        t_sources();
        t_gate_same_cycle();
        t_reserved();
        t_timer();
        t_sysevent();
        t_break();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule